// File: doc/BRIEF.md
# Flash Read-Mode Command Interpreter

This block sits on the host side of a parallel flash memory and decides what the data pins return on a read. It watches command writes from the bus and keeps one of four read modes: the memory array, the identifier codes, the status word or the query table. It also drives a one-hot select for the output data multiplexer and produces the read data for the selected mode.

A command is a single byte written while the chip is selected. It takes effect when write enable returns high. An internal write state machine reports through a busy flag and two suspend flags. While that engine is busy and not suspended, a request to return to array reads is refused and discarded. The identifier and query contents are a small constant table addressed by the low address bits.

Top module: `flash_rdmode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode becomes array (`mode_out` = 0, `sel_out` = 4'b0001). The mode is array after reset.
- R2: Command 0xFF selects array (mode 0). 0x90 selects identifier (mode 1). 0x70 selects status (mode 2). 0x98 selects query (mode 3). `sel_out` is one-hot, with bit n set for mode n.
- R3: A command is taken at the first clock edge where `we_n` is seen high after being low, provided `ce_n` is low. A write whose `we_n` rise happens with `ce_n` high has no effect.
- R4: Any other command byte leaves the mode unchanged. With no command write, the mode holds.
- R5: Command 0xFF written while `wsm_busy` is 1 and both suspend flags are 0 is discarded. The mode stays the same, both at once and after busy clears.
- R6: Command 0xFF written while busy is accepted at once if `erase_susp` or `prog_susp` is 1.
- R7: Commands 0x90, 0x70 and 0x98 are accepted whether or not the engine is busy.
- R8: `data_oe` is 1 exactly when `ce_n` = 0, `oe_n` = 0 and `we_n` = 1. While `data_oe` is 0, `data_out` is 0.
- R9: In status mode, `data_out` bit 7 = not `wsm_busy`, bit 6 = `erase_susp` and bit 2 = `prog_susp`. All other bits are 0.
- R10: In identifier mode, `addr_in[0]` = 0 returns 16'h00A5 and `addr_in[0]` = 1 returns 16'h0017.
- R11: In query mode, `addr_in[1:0]` = 0, 1, 2 and 3 return 16'h0051, 16'h0052, 16'h0059 and 16'h0000.
- R12: In array mode, `data_out` equals `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| cmd_in | input | 8 | Command byte on the bus |
| addr_in | input | 4 | Low address bits for table reads |
| wsm_busy | input | 1 | Write engine is running |
| erase_susp | input | 1 | Running erase is suspended |
| prog_susp | input | 1 | Running program is suspended |
| array_data | input | 16 | Data sensed from the array |
| data_out | output | 16 | Read data to the bus |
| data_oe | output | 1 | Bus drive enable |
| mode_out | output | 2 | Current read mode |
| sel_out | output | 4 | One-hot output mux select |

## Verification
The assertions check the mode register on every cycle. They cover the reset default, holding the mode when no command is written, refusing 0xFF while busy and unsuspended, accepting 0xFF when suspended or idle, and keeping the select one-hot. Only the bench scenarios can show the following: the exact cycle at which a write takes effect, that a write with the chip deselected is ignored, that a refused 0xFF is not replayed once busy clears, and the bit-level contents of the status, identifier and query words under the output gating.

// File: rtl/flash_rdmode_pkg.sv
// Shared types and constants for the flash read-mode interpreter.
// Assumes single-byte commands and a 16-bit data path.
package flash_rdmode_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2,
        MODE_QUERY  = 2'd3
    } rd_mode_e;

    localparam int CMD_W = 8;
    localparam int DATA_W = 16;
    localparam int NUM_MODES = 4;

    localparam logic [CMD_W-1:0] CMD_ARRAY  = 8'hFF;
    localparam logic [CMD_W-1:0] CMD_IDENT  = 8'h90;
    localparam logic [CMD_W-1:0] CMD_STATUS = 8'h70;
    localparam logic [CMD_W-1:0] CMD_QUERY  = 8'h98;

    localparam int ST_READY_BIT = 7;
    localparam int ST_ESUSP_BIT = 6;
    localparam int ST_PSUSP_BIT = 2;
endpackage

// File: rtl/frm_cmd_strobe.sv
// Command strobe: pulses for one clock when a rising edge of write enable
// is seen while the chip is selected. Assumes we_n is synchronous to clk.
module frm_cmd_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic cmd_stb
);
    logic we_q;

    // Remember last sampled write enable; idle high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    // Rising edge of we_n with the chip selected.
    always_comb cmd_stb = !ce_n && we_n && !we_q;
endmodule

// File: rtl/frm_mode_reg.sv
// Read-mode register: decodes command bytes and applies the rule that
// returning to array reads is refused while the write engine runs
// unsuspended. A refused request is discarded.
module frm_mode_reg
    import flash_rdmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_stb,
    input  logic [CMD_W-1:0] cmd_in,
    input  logic             wsm_busy,
    input  logic             erase_susp,
    input  logic             prog_susp,
    output rd_mode_e         mode
);
    rd_mode_e mode_nxt;
    logic     array_ok;

    // Array return allowed when idle or suspended.
    always_comb array_ok = !wsm_busy || erase_susp || prog_susp;

    // Next-mode decode from the command byte.
    always_comb begin
        mode_nxt = mode;
        if (cmd_stb) begin
            unique case (cmd_in)
                CMD_ARRAY:  if (array_ok) mode_nxt = MODE_ARRAY;
                CMD_IDENT:  mode_nxt = MODE_IDENT;
                CMD_STATUS: mode_nxt = MODE_STATUS;
                CMD_QUERY:  mode_nxt = MODE_QUERY;
                default:    mode_nxt = mode;
            endcase
        end
    end

    // Mode register with array default.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_ARRAY;
        else        mode <= mode_nxt;
    end

    // R1
    reset_default_chk: assert property (@(posedge clk) !rst_n |=> mode == MODE_ARRAY);

    // R4
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> $stable(mode));

    // R5
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_in == CMD_ARRAY && wsm_busy && !erase_susp && !prog_susp)
        |=> $stable(mode));

    // R6
    array_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_in == CMD_ARRAY && (!wsm_busy || erase_susp || prog_susp))
        |=> mode == MODE_ARRAY);
endmodule

// File: rtl/frm_data_mux.sv
// Output path: one-hot select from the mode, the status word, the constant
// identifier/query tables and the bus gating. Purely combinational.
module frm_data_mux
    import flash_rdmode_pkg::*;
#(
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00A5,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h0017
) (
    input  rd_mode_e              mode,
    input  logic                  ce_n,
    input  logic                  oe_n,
    input  logic                  we_n,
    input  logic [3:0]            addr_in,
    input  logic                  wsm_busy,
    input  logic                  erase_susp,
    input  logic                  prog_susp,
    input  logic [DATA_W-1:0]     array_data,
    output logic [NUM_MODES-1:0]  sel,
    output logic                  data_oe,
    output logic [DATA_W-1:0]     data_out
);
    logic [DATA_W-1:0] status_w, ident_w, query_w, src_w;

    // Query table entry for a two-bit index.
    function automatic logic [DATA_W-1:0] query_entry(input logic [1:0] idx);
        case (idx)
            2'd0:    return 16'h0051;
            2'd1:    return 16'h0052;
            2'd2:    return 16'h0059;
            default: return '0;
        endcase
    endfunction

    // One select line per mode.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_sel
        assign sel[m] = (mode == rd_mode_e'(m));
    end

    // Status word assembly.
    always_comb begin
        status_w = '0;
        status_w[ST_READY_BIT] = !wsm_busy;
        status_w[ST_ESUSP_BIT] = erase_susp;
        status_w[ST_PSUSP_BIT] = prog_susp;
    end

    // Constant tables.
    always_comb ident_w = addr_in[0] ? DEV_CODE : MFR_CODE;
    always_comb query_w = query_entry(addr_in[1:0]);

    // One-hot source selection.
    always_comb begin
        src_w = '0;
        if (sel[MODE_ARRAY])  src_w = array_data;
        if (sel[MODE_IDENT])  src_w = ident_w;
        if (sel[MODE_STATUS]) src_w = status_w;
        if (sel[MODE_QUERY])  src_w = query_w;
    end

    // Bus gating.
    always_comb data_oe  = !ce_n && !oe_n && we_n;
    always_comb data_out = data_oe ? src_w : '0;
endmodule

// File: rtl/flash_rdmode_ctrl.sv
// Top of the flash read-mode interpreter: strobe detect, mode register and
// output path. Assumes all bus inputs are synchronous to clk.
module flash_rdmode_ctrl
    import flash_rdmode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [7:0]  cmd_in,
    input  logic [3:0]  addr_in,
    input  logic        wsm_busy,
    input  logic        erase_susp,
    input  logic        prog_susp,
    input  logic [15:0] array_data,
    output logic [15:0] data_out,
    output logic        data_oe,
    output logic [1:0]  mode_out,
    output logic [3:0]  sel_out
);
    logic     cmd_stb;
    rd_mode_e mode;

    frm_cmd_strobe u_stb (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cmd_stb(cmd_stb)
    );

    frm_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_in(cmd_in),
        .wsm_busy(wsm_busy), .erase_susp(erase_susp), .prog_susp(prog_susp),
        .mode(mode)
    );

    frm_data_mux u_mux (
        .mode(mode), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr_in(addr_in),
        .wsm_busy(wsm_busy), .erase_susp(erase_susp), .prog_susp(prog_susp),
        .array_data(array_data), .sel(sel_out), .data_oe(data_oe),
        .data_out(data_out)
    );

    assign mode_out = mode;

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_out) && sel_out != 4'b0000);
endmodule

// File: tb/tb_flash_rdmode_ctrl.sv
module tb_flash_rdmode_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ce_n = 1, oe_n = 1, we_n = 1;
    logic [7:0]  cmd_in = 0;
    logic [3:0]  addr_in = 0;
    logic        wsm_busy = 0, erase_susp = 0, prog_susp = 0;
    logic [15:0] array_data = 16'h1234;
    logic [15:0] data_out;
    logic        data_oe;
    logic [1:0]  mode_out;
    logic [3:0]  sel_out;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    flash_rdmode_ctrl dut (.*);

    typedef struct packed {
        logic [7:0] cmd;
        logic busy, esus, psus;
        logic [1:0] exp_mode;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h90, 1'b0, 1'b0, 1'b0, 2'd1},  // R2
        '{8'h70, 1'b0, 1'b0, 1'b0, 2'd2},  // R2
        '{8'h98, 1'b0, 1'b0, 1'b0, 2'd3},  // R2
        '{8'hFF, 1'b0, 1'b0, 1'b0, 2'd0},  // R2
        '{8'h70, 1'b0, 1'b0, 1'b0, 2'd2},  // R2
        '{8'hFF, 1'b1, 1'b0, 1'b0, 2'd2},  // R5
        '{8'h12, 1'b0, 1'b0, 1'b0, 2'd2},  // R4
        '{8'hFF, 1'b1, 1'b1, 1'b0, 2'd0},  // R6
        '{8'h90, 1'b1, 1'b0, 1'b0, 2'd1},  // R7
        '{8'hFF, 1'b1, 1'b0, 1'b1, 2'd0},  // R6
        '{8'h98, 1'b1, 1'b0, 1'b0, 2'd3},  // R7
        '{8'hFF, 1'b1, 1'b0, 1'b0, 2'd3},  // R5
        '{8'hFF, 1'b0, 1'b0, 1'b0, 2'd0}   // R2
    };

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Command write: mode updates at the edge where we_n is first seen high.
    task automatic write_cmd(input logic [7:0] c, input logic sel);
        @(negedge clk); ce_n = ~sel; we_n = 0; cmd_in = c;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic read_at(input logic [3:0] a);
        addr_in = a; ce_n = 0; oe_n = 0; #1;
    endtask

    task automatic read_end();
        ce_n = 1; oe_n = 1;
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(16'(mode_out), 16'd0, "R1 mode after reset");
        check(16'(sel_out), 16'h1, "R1 sel after reset");

        foreach (VECS[i]) begin
            wsm_busy = VECS[i].busy; erase_susp = VECS[i].esus; prog_susp = VECS[i].psus;
            write_cmd(VECS[i].cmd, 1'b1);
            check(16'(mode_out), 16'(VECS[i].exp_mode), $sformatf("R2/R4-R7 vector %0d mode", i));
            check(16'(sel_out), 16'(1 << VECS[i].exp_mode), $sformatf("R2 vector %0d sel", i));
        end
        wsm_busy = 0; erase_susp = 0; prog_susp = 0;

        // R3: deselected write ignored
        write_cmd(8'h70, 1'b0);
        check(16'(mode_out), 16'd0, "R3 deselected write");
        // R3: timing - not yet at the edge before we_n rises
        @(negedge clk); ce_n = 0; we_n = 0; cmd_in = 8'h90;
        @(negedge clk);
        check(16'(mode_out), 16'd0, "R3 no change while we_n low");
        we_n = 1;
        @(negedge clk); ce_n = 1;
        check(16'(mode_out), 16'd1, "R3 change after we_n rise");

        // R10 identifier table
        read_at(4'h0); check(data_out, 16'h00A5, "R10 mfr code");
        read_at(4'h1); check(data_out, 16'h0017, "R10 dev code");
        read_end();

        // R11 query table
        write_cmd(8'h98, 1'b1);
        for (int a = 0; a < 4; a++) begin
            read_at(4'(a));
            check(data_out, (a == 0) ? 16'h0051 : (a == 1) ? 16'h0052 :
                            (a == 2) ? 16'h0059 : 16'h0000, "R11 query entry");
        end
        read_end();

        // R9 status word
        write_cmd(8'h70, 1'b1);
        read_at(4'h0); check(data_out, 16'h0080, "R9 ready idle");
        wsm_busy = 1; erase_susp = 1; #1; check(data_out, 16'h0040, "R9 busy erase susp");
        erase_susp = 0; prog_susp = 1; #1; check(data_out, 16'h0004, "R9 busy prog susp");
        prog_susp = 0; #1; check(data_out, 16'h0000, "R9 busy");
        read_end();

        // R5 not queued: refused while busy, then busy clears
        write_cmd(8'hFF, 1'b1);
        check(16'(mode_out), 16'd2, "R5 refused");
        wsm_busy = 0;
        repeat (3) @(negedge clk);
        check(16'(mode_out), 16'd2, "R5 not replayed");

        // R8 output gating
        read_at(4'h0); check(16'(data_oe), 16'd1, "R8 oe active");
        we_n = 0; #1;
        check(16'(data_oe), 16'd0, "R8 we low gates");
        check(data_out, 16'h0000, "R8 data zero when gated");
        we_n = 1; oe_n = 1; #1;
        check(16'(data_oe), 16'd0, "R8 oe_n high gates");
        read_end();

        // R12 array passthrough
        write_cmd(8'hFF, 1'b1);
        array_data = 16'hBEEF;
        read_at(4'h3); check(data_out, 16'hBEEF, "R12 array data");
        read_end();

        // R1 reset mid-run
        write_cmd(8'h90, 1'b1);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        check(16'(mode_out), 16'd0, "R1 mid-run reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule